// File: doc/BRIEF.md
# Strand-Aware Persist Ordering Queue

This block sits between one processor core and the write port of a nonvolatile memory. The core sends it a stream of commands: a persist (address plus data), a persist barrier, or a new-strand marker. Each persist is held in a small buffer until every earlier persist it truly depends on has been acknowledged by the memory. It is then issued. Persists with no pending constraint may go out concurrently and in any order, up to a fixed number in flight.

A persist depends on two kinds of earlier persist. The first is a persist in the same strand that lies before the most recent barrier of that strand. The second is any persist to the same address, whatever its strand. When no new-strand marker is ever sent, the queue behaves as plain epoch ordering. When a barrier follows every persist, it behaves as strict program order. The memory returns an acknowledgement carrying the buffer tag that was issued. That slot is freed at once and can be reused.

Top module: `persist_order_queue`

## Requirements
- R1: A persist is not issued until every persist that is older in the same strand and separated from it by at least one barrier has been acknowledged. A barrier after every persist therefore gives issue in program order.
- R2: Persists in the same strand with no barrier between them carry no mutual constraint. With no acknowledgements returned, `MAX_OUT` (default 4) such persists are issued.
- R3: After a new-strand command, a persist is not held back by pending persists of earlier strands, except through R4.
- R4: A persist is not issued while an older persist to the same address is unacknowledged, even when that older persist belongs to another strand.
- R5: A barrier sent while the current strand holds no pending persist adds no constraint. A persist that follows it issues even while persists of other strands are outstanding.
- R6: At most one persist is issued per cycle. Among the persists that are eligible, the oldest accepted one is issued first.
- R7: The number of issued but unacknowledged persists never exceeds `MAX_OUT`. Issue pauses while the count equals `MAX_OUT`.
- R8: `cmd_ready` is low while all `DEPTH` (default 8) slots hold persists. No command of any kind is accepted while `cmd_ready` is low.
- R9: After reset the buffer is empty, `cmd_ready` is high and `mem_req_valid` is low.
- R10: An acknowledgement frees its slot in the same edge, and the slot can take a new persist. Every accepted persist is issued exactly once and can be acknowledged.
- R11: An issue presents the persist's own address and data, together with a tag that is not currently outstanding. `cmd_op` encodes 2'b00 persist, 2'b01 barrier, 2'b10 new strand and 2'b11 no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | A free slot exists; the command is taken on this edge |
| cmd_op | input | 2 | Command kind (see R11) |
| cmd_addr | input | AW | Persist address |
| cmd_data | input | DW | Persist data |
| mem_req_valid | output | 1 | A persist is issued this cycle |
| mem_req_tag | output | log2(DEPTH) | Buffer slot of the issued persist |
| mem_req_addr | output | AW | Address of the issued persist |
| mem_req_data | output | DW | Data of the issued persist |
| mem_ack_valid | input | 1 | The memory completes a persist |
| mem_ack_tag | input | log2(DEPTH) | Slot being completed |

## Verification
The bench runs several command patterns and checks what each one shows:
- A run of barrier-free persists with acknowledgements held back shows the concurrency of R2 and the in-flight cap of R7. Releasing single acknowledgements then exposes the oldest-first choice of R6.
- Alternating persist and barrier is checked against strict program order.
- Held acknowledgements across a new-strand marker separate strand independence (R3 and R5) from address conflicts (R4), which must still block.
- A chain of same-address persists fills the buffer and exercises backpressure.
- A random mix of commands with random memory latency is checked at every issue against the predecessor rule.

// File: rtl/pq_pkg.sv
package pq_pkg;

    typedef enum logic [1:0] {
        PQ_OP_PERSIST = 2'b00,
        PQ_OP_BARRIER = 2'b01,
        PQ_OP_STRAND  = 2'b10,
        PQ_OP_NOP     = 2'b11
    } pq_op_e;

endpackage

// File: rtl/pq_slot_alloc.sv
module pq_slot_alloc #(
    parameter int DEPTH = 8,
    localparam int TAGW = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] busy,
    output logic             has_free,
    output logic [TAGW-1:0]  free_tag
);

    // Lowest-numbered free slot wins.
    always_comb begin
        has_free = 1'b0;
        free_tag = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                has_free = 1'b1;
                free_tag = TAGW'(i);
            end
        end
    end

endmodule

// File: rtl/pq_dep_calc.sv
module pq_dep_calc #(
    parameter int DEPTH = 8,
    parameter int AW    = 16
) (
    input  logic [DEPTH-1:0]         live,
    input  logic [DEPTH-1:0]         in_strand,
    input  logic [DEPTH-1:0]         in_epoch,
    input  logic [DEPTH-1:0][AW-1:0] ent_addr,
    input  logic [AW-1:0]            new_addr,
    output logic [DEPTH-1:0]         dep_mask
);

    logic [DEPTH-1:0] addr_hit;
    logic [DEPTH-1:0] epoch_pred;

    // An incoming persist waits on a live entry of its own strand that lies
    // behind a barrier, or on any live entry that writes the same address.
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        assign addr_hit[g]   = (ent_addr[g] == new_addr);
        assign epoch_pred[g] = in_strand[g] & ~in_epoch[g];
        assign dep_mask[g]   = live[g] & (epoch_pred[g] | addr_hit[g]);
    end

endmodule

// File: rtl/pq_issue_sel.sv
module pq_issue_sel #(
    parameter int DEPTH   = 8,
    parameter int MAX_OUT = 4,
    localparam int TAGW   = $clog2(DEPTH),
    localparam int CNTW   = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DEPTH-1:0]            valid,
    input  logic [DEPTH-1:0]            issued,
    input  logic [DEPTH-1:0]            blocked,
    input  logic [DEPTH-1:0][DEPTH-1:0] older,
    output logic                        fire,
    output logic [TAGW-1:0]             tag
);

    logic [DEPTH-1:0] eligible;
    logic [DEPTH-1:0] grant;
    logic [CNTW-1:0]  outstanding;
    logic             allow;

    assign eligible = valid & ~issued & ~blocked;

    // Entry g is granted when no eligible entry is older than it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_age
        assign grant[g] = eligible[g] & ~(|(eligible & older[g]));
    end

    always_comb begin
        outstanding = '0;
        for (int i = 0; i < DEPTH; i++) begin
            outstanding = outstanding + CNTW'(valid[i] & issued[i]);
        end
    end

    assign allow = (outstanding < CNTW'(MAX_OUT));
    assign fire  = allow & (|grant);

    always_comb begin
        tag = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (grant[i]) tag = TAGW'(i);
        end
    end

    // R6
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R7
    outstanding_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding <= CNTW'(MAX_OUT));

endmodule

// File: rtl/persist_order_queue.sv
module persist_order_queue
    import pq_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int AW      = 16,
    parameter int DW      = 32,
    parameter int MAX_OUT = 4,
    localparam int TAGW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [1:0]      cmd_op,
    input  logic [AW-1:0]   cmd_addr,
    input  logic [DW-1:0]   cmd_data,
    output logic            mem_req_valid,
    output logic [TAGW-1:0] mem_req_tag,
    output logic [AW-1:0]   mem_req_addr,
    output logic [DW-1:0]   mem_req_data,
    input  logic            mem_ack_valid,
    input  logic [TAGW-1:0] mem_ack_tag
);

    typedef struct packed {
        logic [DEPTH-1:0]            valid;
        logic [DEPTH-1:0]            issued;
        logic [DEPTH-1:0]            in_strand;  // belongs to the current strand
        logic [DEPTH-1:0]            in_epoch;   // no barrier since it arrived
        logic [DEPTH-1:0][DEPTH-1:0] dep;        // dep[i][j]: i waits on j
        logic [DEPTH-1:0][DEPTH-1:0] older;      // older[i][j]: j arrived before i
        logic [DEPTH-1:0][AW-1:0]    addr;
        logic [DEPTH-1:0][DW-1:0]    data;
    } pq_state_t;

    pq_state_t        s_d, s_q;
    pq_op_e           op;
    logic             accept;
    logic             has_free;
    logic [TAGW-1:0]  alloc_tag;
    logic [DEPTH-1:0] ack_mask;
    logic [DEPTH-1:0] live;
    logic [DEPTH-1:0] new_dep;
    logic [DEPTH-1:0] blocked;
    logic             iss_fire;
    logic [TAGW-1:0]  iss_tag;

    assign op     = pq_op_e'(cmd_op);
    assign accept = cmd_valid & cmd_ready;

    always_comb begin
        ack_mask = '0;
        if (mem_ack_valid) ack_mask[mem_ack_tag] = 1'b1;
    end

    assign live = s_q.valid & ~ack_mask;

    for (genvar g = 0; g < DEPTH; g++) begin : g_blk
        assign blocked[g] = |s_q.dep[g];
    end

    pq_slot_alloc #(.DEPTH(DEPTH)) u_alloc (
        .busy     (s_q.valid),
        .has_free (has_free),
        .free_tag (alloc_tag)
    );

    pq_dep_calc #(.DEPTH(DEPTH), .AW(AW)) u_dep (
        .live      (live),
        .in_strand (s_q.in_strand),
        .in_epoch  (s_q.in_epoch),
        .ent_addr  (s_q.addr),
        .new_addr  (cmd_addr),
        .dep_mask  (new_dep)
    );

    pq_issue_sel #(.DEPTH(DEPTH), .MAX_OUT(MAX_OUT)) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (s_q.valid),
        .issued  (s_q.issued),
        .blocked (blocked),
        .older   (s_q.older),
        .fire    (iss_fire),
        .tag     (iss_tag)
    );

    assign cmd_ready     = has_free;
    assign mem_req_valid = iss_fire;
    assign mem_req_tag   = iss_tag;
    assign mem_req_addr  = s_q.addr[iss_tag];
    assign mem_req_data  = s_q.data[iss_tag];

    always_comb begin
        s_d = s_q;
        // Retire: free the slot and drop every reference to it.
        if (mem_ack_valid) begin
            s_d.valid[mem_ack_tag]  = 1'b0;
            s_d.issued[mem_ack_tag] = 1'b0;
            for (int i = 0; i < DEPTH; i++) begin
                s_d.dep[i][mem_ack_tag]   = 1'b0;
                s_d.older[i][mem_ack_tag] = 1'b0;
            end
        end
        if (iss_fire) s_d.issued[iss_tag] = 1'b1;
        if (accept) begin
            unique case (op)
                PQ_OP_PERSIST: begin
                    s_d.valid[alloc_tag]     = 1'b1;
                    s_d.issued[alloc_tag]    = 1'b0;
                    s_d.in_strand[alloc_tag] = 1'b1;
                    s_d.in_epoch[alloc_tag]  = 1'b1;
                    s_d.addr[alloc_tag]      = cmd_addr;
                    s_d.data[alloc_tag]      = cmd_data;
                    s_d.dep[alloc_tag]       = new_dep;
                    s_d.older[alloc_tag]     = live;
                end
                PQ_OP_BARRIER: s_d.in_epoch = '0;
                PQ_OP_STRAND: begin
                    s_d.in_strand = '0;
                    s_d.in_epoch  = '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Checking aids: remember the most recent acknowledgement.
    logic            ack_seen_q;
    logic [TAGW-1:0] ack_tag_q;
    logic [DEPTH-1:0] dep_col;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_seen_q <= 1'b0;
            ack_tag_q  <= '0;
        end else begin
            ack_seen_q <= mem_ack_valid;
            ack_tag_q  <= mem_ack_tag;
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) dep_col[i] = s_q.dep[i][ack_tag_q];
    end

    // R1 R4
    dep_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_seen_q |-> (dep_col == '0));

    // R10
    retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_seen_q |-> !s_q.valid[ack_tag_q]);

    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> ($countones(s_q.valid) <= $past($countones(s_q.valid))));

    // R11
    fresh_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (s_q.valid[mem_req_tag] && !s_q.issued[mem_req_tag]));

endmodule

// File: tb/persist_order_queue_tb.sv
module persist_order_queue_tb;

    localparam int DEPTH   = 8;
    localparam int AW      = 16;
    localparam int DW      = 32;
    localparam int MAX_OUT = 4;
    localparam int TAGW    = $clog2(DEPTH);
    localparam int NSEQ    = 1024;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic            cmd_ready;
    logic [1:0]      cmd_op = 2'b11;
    logic [AW-1:0]   cmd_addr = '0;
    logic [DW-1:0]   cmd_data = '0;
    logic            mem_req_valid;
    logic [TAGW-1:0] mem_req_tag;
    logic [AW-1:0]   mem_req_addr;
    logic [DW-1:0]   mem_req_data;
    logic            mem_ack_valid = 1'b0;
    logic [TAGW-1:0] mem_ack_tag = '0;

    always #4 clk = ~clk;  // 125 MHz

    persist_order_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .MAX_OUT(MAX_OUT)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .mem_req_valid(mem_req_valid), .mem_req_tag(mem_req_tag),
        .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
        .mem_ack_valid(mem_ack_valid), .mem_ack_tag(mem_ack_tag)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model, indexed by persist sequence number (carried as data).
    int m_strand [NSEQ];
    int m_epoch  [NSEQ];
    int m_addr   [NSEQ];
    bit m_issued [NSEQ];
    bit m_acked  [NSEQ];
    int nseq = 0;
    int cur_strand = 0;
    int cur_epoch  = 0;
    int exp_q[$];
    int issue_log[$];

    // Memory responder state.
    bit busy [DEPTH];
    int timer [DEPTH];
    int seq_of_tag [DEPTH];
    bit auto_ack = 1'b0;
    bit manual_req = 1'b0;
    int manual_tag = 0;
    int acked_total = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Driver: pushes each accepted persist into the expected queue.
    task automatic send(input logic [1:0] op, input int addr);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = AW'(addr);
        cmd_data  = DW'(nseq);
        while (!cmd_ready) @(negedge clk);
        if (op == 2'b00) begin
            m_strand[nseq] = cur_strand;
            m_epoch[nseq]  = cur_epoch;
            m_addr[nseq]   = addr;
            exp_q.push_back(nseq);
            nseq++;
        end else if (op == 2'b01) begin
            cur_epoch++;
        end else if (op == 2'b10) begin
            cur_strand++;
        end
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
    endtask

    task automatic ack_seq(input int s);
        int t;
        t = -1;
        @(posedge clk);
        #1;
        for (int i = 0; i < DEPTH; i++) if (busy[i] && seq_of_tag[i] == s) t = i;
        chk(t >= 0, "R10", "manual ack target outstanding", t, 0);
        if (t >= 0) begin
            manual_tag = t;
            manual_req = 1'b1;
            while (manual_req) @(posedge clk);
        end
    endtask

    task automatic drain();
        int n;
        auto_ack = 1'b1;
        n = 0;
        while (acked_total < nseq && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(acked_total == nseq, "R10", "all accepted persists acknowledged", acked_total, nseq);
    endtask

    // Monitor and memory responder.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack_valid = 1'b0;
        end else begin
            mem_ack_valid = 1'b0;
            if (mem_req_valid) begin
                int s;
                int outs;
                bit ok1;
                bit ok4;
                s = int'(mem_req_data);
                chk(s >= 0 && s < nseq, "R11", "issued data names an accepted persist", s, nseq - 1);
                if (s >= 0 && s < nseq) begin
                    chk(!m_issued[s], "R10", "persist issued once", int'(m_issued[s]), 0);
                    chk(!busy[mem_req_tag], "R11", "tag not outstanding", int'(busy[mem_req_tag]), 0);
                    chk(int'(mem_req_addr) == m_addr[s], "R11", "issued address", int'(mem_req_addr), m_addr[s]);
                    ok1 = 1;
                    ok4 = 1;
                    for (int k = 0; k < s; k++) begin
                        if (!m_acked[k] && m_strand[k] == m_strand[s] && m_epoch[k] < m_epoch[s]) ok1 = 0;
                        if (!m_acked[k] && m_addr[k] == m_addr[s]) ok4 = 0;
                    end
                    chk(ok1, "R1", "earlier-epoch predecessors acknowledged", s, s);
                    chk(ok4, "R4", "same-address predecessors acknowledged", s, s);
                    outs = 1;
                    for (int i = 0; i < DEPTH; i++) if (busy[i]) outs++;
                    chk(outs <= MAX_OUT, "R7", "outstanding after issue", outs, MAX_OUT);
                    m_issued[s] = 1;
                    busy[mem_req_tag] = 1;
                    seq_of_tag[mem_req_tag] = s;
                    timer[mem_req_tag] = $urandom_range(1, 6);
                    issue_log.push_back(s);
                end
            end
            if (manual_req) begin
                mem_ack_valid = 1'b1;
                mem_ack_tag   = TAGW'(manual_tag);
                busy[manual_tag] = 0;
                m_acked[seq_of_tag[manual_tag]] = 1;
                acked_total++;
                manual_req = 1'b0;
            end else if (auto_ack) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (!mem_ack_valid && busy[i] && timer[i] == 0) begin
                        mem_ack_valid = 1'b1;
                        mem_ack_tag   = TAGW'(i);
                        busy[i] = 0;
                        m_acked[seq_of_tag[i]] = 1;
                        acked_total++;
                    end
                end
            end
            for (int i = 0; i < DEPTH; i++) if (busy[i] && timer[i] > 0) timer[i]--;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int base;
        int n0;
        int sa, sb, sc;
        repeat (5) @(negedge clk);
        // R9: state during and right after reset
        chk(cmd_ready == 1'b1, "R9", "ready in reset", int'(cmd_ready), 1);
        chk(mem_req_valid == 1'b0, "R9", "no issue in reset", int'(mem_req_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready && !mem_req_valid, "R9", "idle after reset", int'(mem_req_valid), 0);

        // R2 R6 R7: barrier-free persists, acknowledgements held
        auto_ack = 1'b0;
        base = nseq;
        for (int i = 0; i < 7; i++) send(2'b00, 'h100 + i);
        repeat (10) @(negedge clk);
        chk(issue_log.size() == MAX_OUT, "R2", "concurrent issues without ack", issue_log.size(), MAX_OUT);
        chk(issue_log.size() == MAX_OUT, "R7", "issue paused at cap", issue_log.size(), MAX_OUT);
        for (int i = 0; i < MAX_OUT; i++)
            chk(issue_log[i] == base + i, "R6", "oldest-first issue order", issue_log[i], base + i);
        ack_seq(base + 2);
        repeat (5) @(negedge clk);
        chk(issue_log[issue_log.size() - 1] == base + 4, "R6", "oldest waiting issued after ack",
            issue_log[issue_log.size() - 1], base + 4);
        ack_seq(base + 0);
        repeat (5) @(negedge clk);
        chk(issue_log[issue_log.size() - 1] == base + 5, "R6", "next oldest issued",
            issue_log[issue_log.size() - 1], base + 5);
        drain();

        // R1: barrier after every persist gives program order
        n0 = issue_log.size();
        base = nseq;
        for (int i = 0; i < 8; i++) begin
            send(2'b00, 'h200 + i);
            send(2'b01, 0);
        end
        drain();
        for (int i = 0; i < 8; i++)
            chk(issue_log[n0 + i] == base + i, "R1", "strict program order", issue_log[n0 + i], base + i);

        // R3: a new strand escapes old barriers; R1 inside the new strand
        auto_ack = 1'b0;
        sa = nseq; send(2'b00, 'h300);
        send(2'b01, 0);
        send(2'b10, 0);
        sb = nseq; send(2'b00, 'h301);
        send(2'b01, 0);
        sc = nseq; send(2'b00, 'h302);
        repeat (6) @(negedge clk);
        chk(m_issued[sb] && !m_acked[sa], "R3", "new strand issues past old strand", int'(m_issued[sb]), 1);
        chk(!m_issued[sc], "R1", "barrier holds within new strand", int'(m_issued[sc]), 0);
        drain();

        // R4: same address across strands still ordered
        auto_ack = 1'b0;
        sa = nseq; send(2'b00, 'h400);
        send(2'b10, 0);
        sb = nseq; send(2'b00, 'h400);
        repeat (8) @(negedge clk);
        chk(!m_issued[sb], "R4", "conflicting persist held", int'(m_issued[sb]), 0);
        ack_seq(sa);
        repeat (4) @(negedge clk);
        chk(m_issued[sb], "R4", "conflicting persist released by ack", int'(m_issued[sb]), 1);
        drain();

        // R5: barrier in an empty strand adds nothing
        auto_ack = 1'b0;
        sa = nseq; send(2'b00, 'h500);
        send(2'b01, 0);
        send(2'b10, 0);
        send(2'b01, 0);
        send(2'b01, 0);
        sb = nseq; send(2'b00, 'h501);
        repeat (6) @(negedge clk);
        chk(m_issued[sb] && !m_acked[sa], "R5", "persist after empty-strand barrier issues",
            int'(m_issued[sb]), 1);
        drain();

        // R8 R10: fill the buffer with a same-address chain
        auto_ack = 1'b0;
        sa = nseq;
        for (int i = 0; i < DEPTH; i++) send(2'b00, 'h600);
        @(negedge clk);
        chk(cmd_ready == 1'b0, "R8", "ready low when full", int'(cmd_ready), 0);
        cmd_valid = 1'b1;
        cmd_op    = 2'b01;
        cmd_data  = 32'h7fff_0000;
        repeat (3) begin
            @(negedge clk);
            chk(cmd_ready == 1'b0, "R8", "command refused while full", int'(cmd_ready), 0);
        end
        cmd_op = 2'b00;
        cmd_addr = 'h6ff;
        repeat (3) begin
            @(negedge clk);
            chk(cmd_ready == 1'b0, "R8", "persist refused while full", int'(cmd_ready), 0);
        end
        cmd_valid = 1'b0;
        ack_seq(sa);
        repeat (2) @(negedge clk);
        chk(cmd_ready == 1'b1, "R10", "freed slot reusable", int'(cmd_ready), 1);
        sb = nseq; send(2'b00, 'h601);
        repeat (4) @(negedge clk);
        chk(m_issued[sb], "R10", "reused slot issues", int'(m_issued[sb]), 1);
        drain();

        // Random mix with random latency
        auto_ack = 1'b1;
        for (int i = 0; i < 300; i++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 6)       send(2'b00, 'h700 + $urandom_range(0, 7));
            else if (r < 8)  send(2'b01, 0);
            else if (r == 8) send(2'b10, 0);
            else             send(2'b11, 0);
        end
        drain();

        begin
            int missing;
            missing = 0;
            foreach (exp_q[i]) if (!m_issued[exp_q[i]] || !m_acked[exp_q[i]]) missing++;
            chk(missing == 0, "R10", "every accepted persist issued and acknowledged", missing, 0);
        end
        summary();
    end

endmodule